// File: doc/BRIEF.md
# Selectable Even-Ratio Clock Divider Bank

This block takes one fast internal clock and produces four groups of divided clocks: three fan-out banks (A, B and C, each with several identical pins) and a single feedback output. Every group has its own divider whose ratio comes from a small select code, and every ratio is even, so every output has a 50% duty cycle. A pre-divide control either feeds the dividers with every edge of the internal clock or with every other edge. The block sits behind the frequency synthesizer of a clock generator and in front of the pad drivers.

An active-low master reset, sampled on the internal clock, clears all divider state, drives every output low and lowers an output-enable flag that the pad ring uses to float its drivers. On the first edge after release every divider starts a new period at once, so the first rising edges of all groups coincide. A new select code waits for the divider to finish its current period. An invert control complements a parameterised pair of bank C pins (the third and fourth by default).

Top module: `ratio_div_bank`

## Requirements
- R1: Bank A ratio select 0, 1, 2, 3 (two-bit code, value read as unsigned) gives a period of 4, 6, 8, 12 source ticks.
- R2: Bank B ratio select 0, 1, 2, 3 gives a period of 4, 6, 8, 10 source ticks.
- R3: Bank C ratio select 0, 1, 2, 3 gives a period of 2, 4, 6, 8 source ticks.
- R4: Feedback ratio select 0 to 7 (three-bit code) gives a period of 4, 6, 8, 10, 8, 12, 16, 20 source ticks respectively.
- R5: With the pre-divide input high every clock edge is a source tick; with it low only every second edge is, so every period in clock cycles doubles.
- R6: At each clock edge where the master reset is sampled low, every output pin goes low and the output-enable flag goes low.
- R7: At the first edge where the reset is sampled high after being low, the output-enable flag goes high and every non-inverted output pin goes high together.
- R8: Every output is high for exactly half of its period and low for the other half.
- R9: While enabled, the bank C pins at index 2 and 3 equal the complement of the bank C divider output when the invert input is high and equal it when the invert input is low; the invert input acts at once, without a clock.
- R10: A change of a select code is applied only when the divider reaches the end of its current period; the period in progress finishes with the old ratio.
- R11: All pins of one bank that share an inversion setting carry identical values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal high-rate clock |
| mrst_n_i | input | 1 | Active-low master reset, synchronous |
| pass_i | input | 1 | Pre-divide: 1 uses every clock edge, 0 every second edge |
| sel_a_i | input | 2 | Bank A ratio select |
| sel_b_i | input | 2 | Bank B ratio select |
| sel_c_i | input | 2 | Bank C ratio select |
| sel_fb_i | input | 3 | Feedback ratio select |
| inv_c_i | input | 1 | Invert the selected bank C pins |
| bank_a_o | output | NUM_A | Bank A clock pins |
| bank_b_o | output | NUM_B | Bank B clock pins |
| bank_c_o | output | NUM_C | Bank C clock pins |
| fb_o | output | 1 | Feedback clock |
| out_en_o | output | 1 | Output enable for the pad drivers |

## Verification
On every cycle the assertions check the quiet state under reset, the common rising edge at release, the enable flag while running, the fixed relation between the inverted and plain bank C pins, that the halved source never lets bank C change on two consecutive edges, and that no feedback high phase outlasts the longest allowed one. Exact ratios for each select code, the 50% duty cycle, and the deferral of a new select code to the end of the running period depend on whole sequences of edges, so only the bench scenarios, measured against a tick-level reference model, show them.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

   localparam int unsigned RATIO_W = 5;

   typedef logic [RATIO_W-1:0] ratio_t;

   typedef enum logic [1:0] {
      DIV_KIND_A  = 2'd0,
      DIV_KIND_B  = 2'd1,
      DIV_KIND_C  = 2'd2,
      DIV_KIND_FB = 2'd3
   } div_kind_e;

   // Period length in source ticks for a kind and a select code.
   // Banks A, B and C only decode the low two bits; the upper value
   // range mirrors the lower one so all code bits are consumed.
   function automatic ratio_t ratio_for(div_kind_e kind, logic [2:0] code);
      ratio_t r;
      r = ratio_t'(4);
      unique case (kind)
         DIV_KIND_A: begin
            case (code)
               3'd0, 3'd4: r = ratio_t'(4);
               3'd1, 3'd5: r = ratio_t'(6);
               3'd2, 3'd6: r = ratio_t'(8);
               default:    r = ratio_t'(12);
            endcase
         end
         DIV_KIND_B: begin
            case (code)
               3'd0, 3'd4: r = ratio_t'(4);
               3'd1, 3'd5: r = ratio_t'(6);
               3'd2, 3'd6: r = ratio_t'(8);
               default:    r = ratio_t'(10);
            endcase
         end
         DIV_KIND_C: begin
            case (code)
               3'd0, 3'd4: r = ratio_t'(2);
               3'd1, 3'd5: r = ratio_t'(4);
               3'd2, 3'd6: r = ratio_t'(6);
               default:    r = ratio_t'(8);
            endcase
         end
         default: begin
            case (code)
               3'd0:    r = ratio_t'(4);
               3'd1:    r = ratio_t'(6);
               3'd2:    r = ratio_t'(8);
               3'd3:    r = ratio_t'(10);
               3'd4:    r = ratio_t'(8);
               3'd5:    r = ratio_t'(12);
               3'd6:    r = ratio_t'(16);
               default: r = ratio_t'(20);
            endcase
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rdb_prescale.sv
module rdb_prescale (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic pass_i,
   output logic tick_o
);

   logic phase_q;

   // Phase starts at 1 so the first edge after reset is a tick in both modes.
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         phase_q <= 1'b1;
      end else begin
         phase_q <= ~phase_q;
      end
   end

   assign tick_o = pass_i | phase_q;

endmodule

// File: rtl/rdb_divider.sv
module rdb_divider
   import rdb_pkg::*;
#(
   parameter div_kind_e   KIND  = DIV_KIND_A,
   parameter int unsigned CW    = RATIO_W,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             q_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   if (CW < RATIO_W) begin : g_bad_width
      $error("rdb_divider: CW too narrow for the largest ratio");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("rdb_divider: select must be three bits wide");
   end

   logic [CW-1:0] ratio_d;
   logic [CW-1:0] ratio_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] half;
   logic          last;
   logic          mid;
   logic          q_q;

   always_comb begin
      ratio_d = CW'(ratio_for(KIND, sel_i));
   end

   assign half = ratio_q >> 1;
   assign last = (cnt_q == ratio_q - ONE);
   assign mid  = (cnt_q == half - ONE);

   // Counter is parked on its terminal value during reset, so the first
   // tick after release wraps every divider on the same edge.
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         ratio_q <= ratio_d;
         cnt_q   <= ratio_d - ONE;
         q_q     <= 1'b0;
      end else if (tick_i) begin
         if (last) begin
            cnt_q   <= '0;
            ratio_q <= ratio_d;
            q_q     <= 1'b1;
         end else begin
            cnt_q <= cnt_q + ONE;
            if (mid) begin
               q_q <= 1'b0;
            end
         end
      end
   end

   assign q_o = q_q;

endmodule

// File: rtl/rdb_fanout.sv
module rdb_fanout #(
   parameter int unsigned W      = 4,
   parameter int unsigned INV_LO = 0,
   parameter int unsigned INV_N  = 0
) (
   input  logic         en_i,
   input  logic         q_i,
   input  logic         inv_i,
   output logic [W-1:0] pins_o
);

   if (W < 1) begin : g_bad_w
      $error("rdb_fanout: at least one pin required");
   end
   if (INV_N > 0 && INV_LO + INV_N > W) begin : g_bad_inv
      $error("rdb_fanout: invert range exceeds pin count");
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      localparam bit FLIP = (i >= INV_LO) && (i < INV_LO + INV_N);
      assign pins_o[i] = en_i & (q_i ^ (inv_i & FLIP));
   end

endmodule

// File: rtl/ratio_div_bank.sv
module ratio_div_bank
   import rdb_pkg::*;
#(
   parameter int unsigned NUM_A  = 4,
   parameter int unsigned NUM_B  = 4,
   parameter int unsigned NUM_C  = 4,
   parameter int unsigned INV_LO = 2,
   parameter int unsigned INV_N  = 2,
   parameter int unsigned CW     = RATIO_W
) (
   input  logic             clk_i,
   input  logic             mrst_n_i,
   input  logic             pass_i,
   input  logic [1:0]       sel_a_i,
   input  logic [1:0]       sel_b_i,
   input  logic [1:0]       sel_c_i,
   input  logic [2:0]       sel_fb_i,
   input  logic             inv_c_i,
   output logic [NUM_A-1:0] bank_a_o,
   output logic [NUM_B-1:0] bank_b_o,
   output logic [NUM_C-1:0] bank_c_o,
   output logic             fb_o,
   output logic             out_en_o
);

   if (INV_LO + INV_N > NUM_C) begin : g_bad_cfg
      $error("ratio_div_bank: inverted pins fall outside bank C");
   end

   logic tick;
   logic en_q;
   logic q_a;
   logic q_b;
   logic q_c;
   logic q_fb;

   always_ff @(posedge clk_i) begin
      if (!mrst_n_i) begin
         en_q <= 1'b0;
      end else begin
         en_q <= 1'b1;
      end
   end

   rdb_prescale u_pre (
      .clk_i   (clk_i),
      .rst_n_i (mrst_n_i),
      .pass_i  (pass_i),
      .tick_o  (tick)
   );

   rdb_divider #(.KIND(DIV_KIND_A), .CW(CW)) u_div_a (
      .clk_i (clk_i), .rst_n_i (mrst_n_i), .tick_i (tick),
      .sel_i ({1'b0, sel_a_i}), .q_o (q_a)
   );

   rdb_divider #(.KIND(DIV_KIND_B), .CW(CW)) u_div_b (
      .clk_i (clk_i), .rst_n_i (mrst_n_i), .tick_i (tick),
      .sel_i ({1'b0, sel_b_i}), .q_o (q_b)
   );

   rdb_divider #(.KIND(DIV_KIND_C), .CW(CW)) u_div_c (
      .clk_i (clk_i), .rst_n_i (mrst_n_i), .tick_i (tick),
      .sel_i ({1'b0, sel_c_i}), .q_o (q_c)
   );

   rdb_divider #(.KIND(DIV_KIND_FB), .CW(CW)) u_div_fb (
      .clk_i (clk_i), .rst_n_i (mrst_n_i), .tick_i (tick),
      .sel_i (sel_fb_i), .q_o (q_fb)
   );

   rdb_fanout #(.W(NUM_A), .INV_LO(0), .INV_N(0)) u_fan_a (
      .en_i (en_q), .q_i (q_a), .inv_i (1'b0), .pins_o (bank_a_o)
   );

   rdb_fanout #(.W(NUM_B), .INV_LO(0), .INV_N(0)) u_fan_b (
      .en_i (en_q), .q_i (q_b), .inv_i (1'b0), .pins_o (bank_b_o)
   );

   rdb_fanout #(.W(NUM_C), .INV_LO(INV_LO), .INV_N(INV_N)) u_fan_c (
      .en_i (en_q), .q_i (q_c), .inv_i (inv_c_i), .pins_o (bank_c_o)
   );

   rdb_fanout #(.W(1), .INV_LO(0), .INV_N(0)) u_fan_fb (
      .en_i (en_q), .q_i (q_fb), .inv_i (1'b0), .pins_o (fb_o)
   );

   assign out_en_o = en_q;

endmodule

// File: rtl/ratio_div_bank_chk.sv
module ratio_div_bank_chk #(
   parameter int unsigned NUM_A  = 4,
   parameter int unsigned NUM_B  = 4,
   parameter int unsigned NUM_C  = 4,
   parameter int unsigned INV_LO = 2
) (
   input logic             clk_i,
   input logic             mrst_n_i,
   input logic             pass_i,
   input logic             inv_c_i,
   input logic [NUM_A-1:0] bank_a_o,
   input logic [NUM_B-1:0] bank_b_o,
   input logic [NUM_C-1:0] bank_c_o,
   input logic             fb_o,
   input logic             out_en_o
);

   localparam int unsigned FB_HI_MAX = 20;

   logic [7:0] fb_hi_q;

   always_ff @(posedge clk_i) begin
      if (!mrst_n_i || !fb_o) begin
         fb_hi_q <= '0;
      end else if (fb_hi_q != 8'hFF) begin
         fb_hi_q <= fb_hi_q + 8'd1;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !mrst_n_i |=> (!out_en_o && bank_a_o == '0 && bank_b_o == '0 && bank_c_o == '0 && !fb_o)); // R6

   AST_RELEASE_ALIGN: assert property (@(posedge clk_i)
      $rose(mrst_n_i) |=> (out_en_o && (&bank_a_o) && (&bank_b_o) && bank_c_o[0] && fb_o)); // R7

   AST_ENABLE_HELD: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
      $past(mrst_n_i) |-> out_en_o); // R7

   AST_INV_PAIR: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
      out_en_o |-> (bank_c_o[INV_LO] == (bank_c_o[0] ^ inv_c_i))); // R9

   AST_HALF_RATE: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
      (!pass_i && !$past(pass_i) && $past(mrst_n_i) && (bank_c_o[0] != $past(bank_c_o[0])))
      |=> $stable(bank_c_o[0])); // R5

   AST_FB_HIGH_SPAN: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
      fb_hi_q <= 8'(FB_HI_MAX)); // R8

endmodule

bind ratio_div_bank ratio_div_bank_chk #(
   .NUM_A (NUM_A),
   .NUM_B (NUM_B),
   .NUM_C (NUM_C),
   .INV_LO(INV_LO)
) u_chk (
   .clk_i    (clk_i),
   .mrst_n_i (mrst_n_i),
   .pass_i   (pass_i),
   .inv_c_i  (inv_c_i),
   .bank_a_o (bank_a_o),
   .bank_b_o (bank_b_o),
   .bank_c_o (bank_c_o),
   .fb_o     (fb_o),
   .out_en_o (out_en_o)
);

// File: tb/ratio_div_bank_bench.sv
module ratio_div_bank_bench;

   localparam int NA = 4;
   localparam int NB = 4;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pass = 1'b1;
   logic [1:0]    sel_a = 2'd0;
   logic [1:0]    sel_b = 2'd0;
   logic [1:0]    sel_c = 2'd0;
   logic [2:0]    sel_fb = 3'd0;
   logic          inv = 1'b0;
   logic [NA-1:0] bank_a;
   logic [NB-1:0] bank_b;
   logic [NC-1:0] bank_c;
   logic          fb;
   logic          en;

   int n_chk = 0;
   int n_fail = 0;

   ratio_div_bank u_ratio_div_bank (
      .clk_i (clk), .mrst_n_i (rst_n), .pass_i (pass),
      .sel_a_i (sel_a), .sel_b_i (sel_b), .sel_c_i (sel_c), .sel_fb_i (sel_fb),
      .inv_c_i (inv), .bank_a_o (bank_a), .bank_b_o (bank_b), .bank_c_o (bank_c),
      .fb_o (fb), .out_en_o (en)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Period table per group (0=A, 1=B, 2=C, 3=feedback), from the requirements.
   function automatic int dec(input int k, input int s);
      int a[4] = '{4, 6, 8, 12};
      int b[4] = '{4, 6, 8, 10};
      int c[4] = '{2, 4, 6, 8};
      int f[8] = '{4, 6, 8, 10, 8, 12, 16, 20};
      case (k)
         0: return a[s & 3];
         1: return b[s & 3];
         2: return c[s & 3];
         default: return f[s & 7];
      endcase
   endfunction

   function automatic int cur_sel(input int k);
      case (k)
         0: return int'(sel_a);
         1: return int'(sel_b);
         2: return int'(sel_c);
         default: return int'(sel_fb);
      endcase
   endfunction

   // Tick-level reference: phase within period, ratio in force, output level.
   int ph[4];
   int rat[4];
   bit mq[4];
   bit m_en = 1'b0;
   bit m_pre = 1'b1;
   bit m_valid = 1'b0;

   always @(posedge clk) begin
      bit tk;
      if (!rst_n) begin
         m_en = 1'b0;
         m_pre = 1'b1;
         for (int k = 0; k < 4; k++) begin
            rat[k] = dec(k, cur_sel(k));
            ph[k] = rat[k] - 1;
            mq[k] = 1'b0;
         end
      end else begin
         tk = pass | m_pre;
         m_pre = ~m_pre;
         m_en = 1'b1;
         if (tk) begin
            for (int k = 0; k < 4; k++) begin
               if (ph[k] == rat[k] - 1) begin
                  ph[k] = 0;
                  rat[k] = dec(k, cur_sel(k));   // R10: new code only at wrap
               end else begin
                  ph[k] = ph[k] + 1;
               end
               mq[k] = (ph[k] < rat[k] / 2);     // R8
            end
         end
      end
      m_valid = 1'b1;
   end

   // Scoreboard on every falling edge.
   always @(negedge clk) begin
      if (m_valid) begin
         chk(en == m_en, "R6 R7 enable", int'(en), int'(m_en));
         for (int i = 0; i < NA; i++)
            chk(bank_a[i] == mq[0], "R1 R11 bank A", int'(bank_a[i]), int'(mq[0]));
         for (int i = 0; i < NB; i++)
            chk(bank_b[i] == mq[1], "R2 R11 bank B", int'(bank_b[i]), int'(mq[1]));
         for (int i = 0; i < NC; i++) begin
            bit fl;
            bit ex;
            fl = inv && (i >= 2) && (i < 4);
            ex = m_en & (mq[2] ^ fl);
            chk(bank_c[i] == ex, fl ? "R9 bank C inverted" : "R3 R11 bank C",
                int'(bank_c[i]), int'(ex));
         end
         chk(fb == mq[3], "R4 R10 feedback", int'(fb), int'(mq[3]));
      end
   end

   task automatic do_reset(input bit p, input int code_fb);
      @(posedge clk); #2;
      rst_n = 1'b0;
      pass = p;
      sel_fb = 3'(code_fb);
      inv = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      chk(!en && bank_a == '0 && bank_b == '0 && bank_c == '0 && !fb,
          "R6 quiet in reset", int'({en, fb}), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(en && (&bank_a) && (&bank_b) && bank_c[0] && fb,
          "R7 common first rise", int'({en, fb, bank_c[0]}), 7);
   endtask

   // Called at a falling edge where fb has just risen; ends at the next such edge.
   task automatic span(input int exp_hi, input int exp_lo, input int nxt, input string tag);
      int hi = 1;
      int lo = 0;
      if (nxt >= 0) begin
         @(posedge clk); #2;
         sel_fb = 3'(nxt);
      end
      @(negedge clk);
      while (fb === 1'b1) begin hi++; @(negedge clk); end
      while (fb === 1'b0) begin lo++; @(negedge clk); end
      chk(hi == exp_hi, {tag, " high span"}, hi, exp_hi);
      chk(lo == exp_lo, {tag, " low span"}, lo, exp_lo);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));

      // R4 R8: each feedback code, full-rate source.
      for (int code = 0; code < 8; code++) begin
         do_reset(1'b1, code);
         span(dec(3, code) / 2, dec(3, code) / 2, -1, "R4 R8");
      end

      // R5: halved source doubles every span.
      do_reset(1'b0, 0);
      span(4, 4, -1, "R5");
      do_reset(1'b0, 7);
      span(20, 20, -1, "R5");

      // R10: switch /20 to /4 early in a period.
      do_reset(1'b1, 7);
      span(10, 10, 0, "R10 old ratio");
      span(2, 2, -1, "R10 new ratio");

      // Constrained random: codes, inversion, pre-divide and short resets.
      for (int n = 0; n < 6000; n++) begin
         @(posedge clk); #2;
         if ($urandom % 16 == 0) sel_a = 2'($urandom);
         if ($urandom % 16 == 0) sel_b = 2'($urandom);
         if ($urandom % 16 == 0) sel_c = 2'($urandom);
         if ($urandom % 16 == 0) sel_fb = 3'($urandom);
         if ($urandom % 8 == 0) inv = ~inv;
         if ($urandom % 300 == 0) pass = ~pass;
         rst_n = ($urandom % 400 != 0);
      end
      @(posedge clk); #2;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule